// File: doc/BRIEF.md
# Register-Register ALU Operation Decoder

This block sits between the main instruction decoder and the ALU of a 64-bit in-order integer core. It takes a 3-bit class code that says what kind of instruction is in flight, together with the two function fields of a register-register instruction (the 7-bit upper field, bits 31..25, and the 3-bit middle field, bits 14..12). From these it produces the 5-bit operation code that the ALU consumes.

Two classes are decoded: full-width (64-bit) register-register instructions and word (32-bit) register-register instructions. Each covers the base integer operations and the multiply/divide operations. The operation encoding is fixed by the ALU and is not contiguous. Every combination that does not name a supported operation yields the reserved code 11111, which the ALU treats as invalid. Immediate, load/store and address-generation classes are outside this block and also yield 11111. The block is purely combinational, so its output follows its inputs in the same cycle.

Top module: `alu_op_decode`

## Requirements
- R1: For any class code other than 1 (64-bit register-register) or 3 (32-bit register-register), including 0, 2, 4, 5, 6 and 7, the output is 11111 whatever the function fields hold.
- R2: With class 1 and upper field 0000000, middle field 0..7 gives add 00000, sll 10010, slt 10110, sltu 10111, xor 01111, srl 10100, or 01110 and and 01101, in that order of middle-field value.
- R3: With upper field 0100000, middle field 000 gives sub 00010 and middle field 101 gives sra 10000 under class 1. Under class 3 the same fields give subw 00100 and sraw 10001. Every other middle-field value gives 11111 in both classes.
- R4: With class 1 and upper field 0000001, middle field 0..7 gives mul 00101, mulh 00111, mulhsu 11000, mulhu 01000, div 01001, divu 01010, rem 11100 and remu 11011.
- R5: With class 3 and upper field 0000000, middle field 000 gives addw 00001, 001 gives sllw 10011 and 101 gives srlw 10101. Middle fields 010, 011, 100, 110 and 111 give 11111.
- R6: With class 3 and upper field 0000001, middle field 000 gives mulw 00110, 100 gives divw 01011, 101 gives divuw 01100, 110 gives remw 11010 and 111 gives remuw 11001. Middle fields 001, 010 and 011 give 11111.
- R7: Under class 1 or 3, an upper field other than 0000000, 0100000 or 0000001 gives 11111 for every middle-field value.
- R8: The output never takes the unassigned codes 00011, 11101 or 11110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 3 | Instruction class code: 1 = 64-bit register-register, 3 = 32-bit register-register, other values undecoded |
| f7_i | input | 7 | Upper function field of the instruction (bits 31..25) |
| f3_i | input | 3 | Middle function field of the instruction (bits 14..12) |
| op_o | output | 5 | ALU operation code; 11111 marks an invalid combination |

## Verification
A wrong decode path here has no hidden state to hide behind. It shows up at once on op_o, in the same cycle as the offending input, either as a wrong operation code or as a missing 11111. The subtle faults are the ones that keep a plausible code: a word form leaking into 64-bit class, a stray code for a word-mode middle field that has no word form, or an upper field with one unexpected bit set that is still accepted. For that reason every one of the 8192 input combinations is compared against a model built from the requirement lists.

// File: rtl/alu_op_decode.sv
module alu_op_decode #(
  parameter int CLS_W = 3,
  parameter int F7_W  = 7,
  parameter int F3_W  = 3,
  parameter int OP_W  = 5
) (
  input  logic [CLS_W-1:0] cls_i,
  input  logic [F7_W-1:0]  f7_i,
  input  logic [F3_W-1:0]  f3_i,
  output logic [OP_W-1:0]  op_o
);

  localparam logic [CLS_W-1:0] CLS_DW = CLS_W'(1);
  localparam logic [CLS_W-1:0] CLS_W32 = CLS_W'(3);

  localparam logic [F7_W-1:0] F7_PLAIN = F7_W'(7'b0000000);
  localparam logic [F7_W-1:0] F7_ALT   = F7_W'(7'b0100000);
  localparam logic [F7_W-1:0] F7_MD    = F7_W'(7'b0000001);

  localparam logic [OP_W-1:0] OP_ADD    = OP_W'(5'b00000);
  localparam logic [OP_W-1:0] OP_ADDW   = OP_W'(5'b00001);
  localparam logic [OP_W-1:0] OP_SUB    = OP_W'(5'b00010);
  localparam logic [OP_W-1:0] OP_SUBW   = OP_W'(5'b00100);
  localparam logic [OP_W-1:0] OP_MUL    = OP_W'(5'b00101);
  localparam logic [OP_W-1:0] OP_MULW   = OP_W'(5'b00110);
  localparam logic [OP_W-1:0] OP_MULH   = OP_W'(5'b00111);
  localparam logic [OP_W-1:0] OP_MULHU  = OP_W'(5'b01000);
  localparam logic [OP_W-1:0] OP_DIV    = OP_W'(5'b01001);
  localparam logic [OP_W-1:0] OP_DIVU   = OP_W'(5'b01010);
  localparam logic [OP_W-1:0] OP_DIVW   = OP_W'(5'b01011);
  localparam logic [OP_W-1:0] OP_DIVUW  = OP_W'(5'b01100);
  localparam logic [OP_W-1:0] OP_AND    = OP_W'(5'b01101);
  localparam logic [OP_W-1:0] OP_OR     = OP_W'(5'b01110);
  localparam logic [OP_W-1:0] OP_XOR    = OP_W'(5'b01111);
  localparam logic [OP_W-1:0] OP_SRA    = OP_W'(5'b10000);
  localparam logic [OP_W-1:0] OP_SRAW   = OP_W'(5'b10001);
  localparam logic [OP_W-1:0] OP_SLL    = OP_W'(5'b10010);
  localparam logic [OP_W-1:0] OP_SLLW   = OP_W'(5'b10011);
  localparam logic [OP_W-1:0] OP_SRL    = OP_W'(5'b10100);
  localparam logic [OP_W-1:0] OP_SRLW   = OP_W'(5'b10101);
  localparam logic [OP_W-1:0] OP_SLT    = OP_W'(5'b10110);
  localparam logic [OP_W-1:0] OP_SLTU   = OP_W'(5'b10111);
  localparam logic [OP_W-1:0] OP_MULHSU = OP_W'(5'b11000);
  localparam logic [OP_W-1:0] OP_REMUW  = OP_W'(5'b11001);
  localparam logic [OP_W-1:0] OP_REMW   = OP_W'(5'b11010);
  localparam logic [OP_W-1:0] OP_REMU   = OP_W'(5'b11011);
  localparam logic [OP_W-1:0] OP_REM    = OP_W'(5'b11100);
  localparam logic [OP_W-1:0] OP_BAD    = OP_W'(5'b11111);

  logic dw, wd;
  logic [OP_W-1:0] op_q;

  assign dw = (cls_i == CLS_DW);
  assign wd = (cls_i == CLS_W32);

  always_comb begin
    op_q = OP_BAD;
    if (dw || wd) begin
      case (f7_i)
        F7_PLAIN: begin
          case (f3_i)
            3'd0: op_q = wd ? OP_ADDW : OP_ADD;
            3'd1: op_q = wd ? OP_SLLW : OP_SLL;
            3'd2: if (dw) op_q = OP_SLT;
            3'd3: if (dw) op_q = OP_SLTU;
            3'd4: if (dw) op_q = OP_XOR;
            3'd5: op_q = wd ? OP_SRLW : OP_SRL;
            3'd6: if (dw) op_q = OP_OR;
            3'd7: if (dw) op_q = OP_AND;
            default: op_q = OP_BAD;
          endcase
        end
        F7_ALT: begin
          case (f3_i)
            3'd0: op_q = wd ? OP_SUBW : OP_SUB;
            3'd5: op_q = wd ? OP_SRAW : OP_SRA;
            default: op_q = OP_BAD;
          endcase
        end
        F7_MD: begin
          case (f3_i)
            3'd0: op_q = wd ? OP_MULW : OP_MUL;
            3'd1: if (dw) op_q = OP_MULH;
            3'd2: if (dw) op_q = OP_MULHSU;
            3'd3: if (dw) op_q = OP_MULHU;
            3'd4: op_q = wd ? OP_DIVW : OP_DIV;
            3'd5: op_q = wd ? OP_DIVUW : OP_DIVU;
            3'd6: op_q = wd ? OP_REMW : OP_REM;
            3'd7: op_q = wd ? OP_REMUW : OP_REMU;
            default: op_q = OP_BAD;
          endcase
        end
        default: op_q = OP_BAD;
      endcase
    end
  end

  assign op_o = op_q;

  always_comb begin
    if (cls_i != CLS_DW && cls_i != CLS_W32)
      AST_CLASS_GATE: assert (op_o == OP_BAD); // R1
    if (f7_i != F7_PLAIN && f7_i != F7_ALT && f7_i != F7_MD)
      AST_F7_GATE: assert (op_o == OP_BAD); // R7
    AST_NO_SPARE: assert (op_o != OP_W'(5'b00011) && op_o != OP_W'(5'b11101) && op_o != OP_W'(5'b11110)); // R8
    if (op_o == OP_ADDW || op_o == OP_SLLW || op_o == OP_SRLW || op_o == OP_MULW || op_o == OP_DIVW ||
        op_o == OP_DIVUW || op_o == OP_REMW || op_o == OP_REMUW)
      AST_WORD_ONLY: assert (cls_i == CLS_W32); // R5
    if (f7_i == F7_ALT && op_o != OP_BAD)
      AST_ALT_F3: assert (f3_i == 3'd0 || f3_i == 3'd5); // R3
    if (op_o == OP_MULH || op_o == OP_MULHSU || op_o == OP_MULHU || op_o == OP_REM || op_o == OP_REMU)
      AST_MD_64: assert (f7_i == F7_MD && cls_i == CLS_DW); // R4
  end

endmodule

// File: tb/tb_alu_op_decode.sv
module tb_alu_op_decode;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2:0] cls;
  logic [6:0] f7;
  logic [2:0] f3;
  logic [4:0] op;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu_op_decode dut (.cls_i(cls), .f7_i(f7), .f3_i(f3), .op_o(op));

  localparam logic [4:0] BAD = 5'b11111;
  localparam logic [4:0] T_PLAIN64 [8] = '{5'b00000, 5'b10010, 5'b10110, 5'b10111,
                                           5'b01111, 5'b10100, 5'b01110, 5'b01101};
  localparam logic [4:0] T_MD64 [8]    = '{5'b00101, 5'b00111, 5'b11000, 5'b01000,
                                           5'b01001, 5'b01010, 5'b11100, 5'b11011};
  localparam logic [4:0] T_PLAIN32 [8] = '{5'b00001, 5'b10011, BAD, BAD,
                                           BAD, 5'b10101, BAD, BAD};
  localparam logic [4:0] T_MD32 [8]    = '{5'b00110, BAD, BAD, BAD,
                                           5'b01011, 5'b01100, 5'b11010, 5'b11001};

  function automatic logic [4:0] expect_alt(input int c, input int g3);
    if (g3 == 0) return (c == 3) ? 5'b00100 : 5'b00010;
    if (g3 == 5) return (c == 3) ? 5'b10001 : 5'b10000;
    return BAD;
  endfunction

  task automatic apply_chk(input int c, input int g7, input int g3, input logic [4:0] exp, input string req);
    cls = 3'(c); f7 = 7'(g7); f3 = 3'(g3);
    #1;
    n_chk++;
    if (op !== exp) begin
      n_bad++;
      $display("FAIL %s cls=%0d f7=%b f3=%0d got=%b exp=%b", req, c, 7'(g7), g3, op, exp);
    end
  endtask

  task automatic t_idle_start;
    apply_chk(0, 0, 0, BAD, "R1");
  endtask

  task automatic t_other_classes;
    foreach (T_PLAIN64[k]) begin end
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 3) continue;
      for (int g7 = 0; g7 < 128; g7++)
        for (int g3 = 0; g3 < 8; g3++) apply_chk(c, g7, g3, BAD, "R1");
    end
  endtask

  task automatic t_plain64;
    for (int g3 = 0; g3 < 8; g3++) apply_chk(1, 7'b0000000, g3, T_PLAIN64[g3], "R2");
  endtask

  task automatic t_alt_both;
    for (int g3 = 0; g3 < 8; g3++) begin
      apply_chk(1, 7'b0100000, g3, expect_alt(1, g3), "R3");
      apply_chk(3, 7'b0100000, g3, expect_alt(3, g3), "R3");
    end
  endtask

  task automatic t_md64;
    for (int g3 = 0; g3 < 8; g3++) apply_chk(1, 7'b0000001, g3, T_MD64[g3], "R4");
  endtask

  task automatic t_plain32;
    for (int g3 = 0; g3 < 8; g3++) apply_chk(3, 7'b0000000, g3, T_PLAIN32[g3], "R5");
  endtask

  task automatic t_md32;
    for (int g3 = 0; g3 < 8; g3++) apply_chk(3, 7'b0000001, g3, T_MD32[g3], "R6");
  endtask

  task automatic t_bad_upper;
    for (int g7 = 0; g7 < 128; g7++) begin
      if (g7 == 0 || g7 == 1 || g7 == 32) continue;
      for (int g3 = 0; g3 < 8; g3++) begin
        apply_chk(1, g7, g3, BAD, "R7");
        apply_chk(3, g7, g3, BAD, "R7");
      end
    end
  endtask

  task automatic t_spare_codes;
    for (int c = 0; c < 8; c++)
      for (int g7 = 0; g7 < 128; g7++)
        for (int g3 = 0; g3 < 8; g3++) begin
          cls = 3'(c); f7 = 7'(g7); f3 = 3'(g3);
          #1;
          n_chk++;
          if (op == 5'b00011 || op == 5'b11101 || op == 5'b11110) begin
            n_bad++;
            $display("FAIL R8 cls=%0d f7=%b f3=%0d got=%b exp=assigned code", c, 7'(g7), g3, op);
          end
        end
  endtask

  initial begin
    cls = '0; f7 = '0; f3 = '0;
    @(negedge clk);
    t_idle_start();
    t_plain64();
    t_alt_both();
    t_md64();
    t_plain32();
    t_md32();
    t_bad_upper();
    t_other_classes();
    t_spare_codes();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=timeout exp=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule